// File: doc/BRIEF.md
# Channel-Partitioned Audio Transmit FIFO

This block is the sample store on the transmit side of a serial audio output port. A host pushes interleaved 24-bit sample words through a data register. A downstream serializer removes them one word per `pop_i` strobe. One shared memory of `DEPTH` words is divided by the programmed channel count, so each channel gets a fixed power-of-two share. The usable word capacity is that share multiplied by the channel count.

The host works through a single-cycle write strobe with a 2-bit register select, and reads through a combinational read port. The registers are:

| Address | Register |
|---------|----------|
| 0 | control |
| 1 | status |
| 2 | format |
| 3 | data (write only) |

The status word reports how many frames are held, plus sticky overrun and underrun flags. A level request tells the host when the store has drained to half of its capacity, so it can refill. A flush command empties the store without touching the error flags.

Top module: `audio_tx_fifo`

## Requirements
- R1: A write to the data register (address 3) stores only bits 23:0 of the write data; bits 31:24 have no effect. `sample_o` presents the oldest stored word, in write order. A 16-bit sample placed in bits 23:8 therefore emerges at `sample_o[23:8]`.
- R2: The format register (address 2, bits 2:0 = channel count minus 1) sets the words per channel: `DEPTH` for 1 channel, `DEPTH/2` for 2, `DEPTH/4` for 3 or 4, and `DEPTH/8` for 5 to 8. The capacity in words is the words per channel times the channel count.
- R3: Status (address 1) bits 16:8 hold the frame count. This is the number of frames written completely minus the number of frames read completely, counted from the last flush. All other status bits apart from 4 and 0 read 0.
- R4: A data write while the store holds its full capacity is dropped and sets the sticky overrun flag, status bit 4.
- R5: A pop while the store is empty changes nothing stored, shows 0 on `sample_o`, and sets the sticky underrun flag, status bit 0.
- R6: A status write with 0 in bit 4 clears the overrun flag, and a status write with 0 in bit 0 clears the underrun flag. A 1 in either position leaves that flag as it was.
- R7: Control bit 20 enables the half-level request. `half_req_o` is 1 exactly when the enable is set and the stored word count is at most half the capacity (rounded down).
- R8: Writing control with bit 0 set empties the store and zeroes the frame count. Control bit 0 always reads back 0, and the error flags are kept.
- R9: Any write to the format register also empties the store.
- R10: After reset the store is empty, both flags are 0, the channel count is 1, the half-level enable is 0, and `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 format, 3 data |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data of the selected register (data register reads 0) |
| pop_i | input | 1 | Serializer takes one word |
| sample_o | output | 24 | Oldest stored word, 0 when empty |
| half_req_o | output | 1 | Half-level refill request |

## Verification
The bench builds the block with `DEPTH` = 32, which shrinks every per-channel share to between 4 and 32 words. At that size, all eight channel counts can be filled word by word to capacity, pushed once past it, and drained once past empty within a short run. Frame counts, the half-level threshold and the data order are computed arithmetically at every step. This reaches the odd-capacity settings (3, 5, 6 and 7 channels), the full and empty edges, flag set and clear, and flushes issued both from the control register and from a format change.

// File: rtl/audio_tx_fifo_pkg.sv
package audio_tx_fifo_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned FRAME_W  = 9;
  localparam int unsigned CHSEL_W  = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_FMT  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_FLUSH_BIT = 0;
  localparam int unsigned CTRL_HALF_BIT  = 20;
  localparam int unsigned STAT_UNDER_BIT = 0;
  localparam int unsigned STAT_OVER_BIT  = 4;
  localparam int unsigned STAT_FRAME_LSB = 8;
endpackage

// File: rtl/tx_reg_ctrl.sv
module tx_reg_ctrl
  import audio_tx_fifo_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [1:0]            addr_i,
  input  logic [31:0]           wdata_i,
  input  logic                  over_evt_i,
  input  logic                  under_evt_i,
  input  logic [FRAME_W-1:0]    frames_i,
  output logic [31:0]           rdata_o,
  output logic                  half_en_o,
  output logic [CHSEL_W-1:0]    chm1_o,
  output logic                  flush_o,
  output logic                  push_o,
  output logic [SAMPLE_W-1:0]   push_data_o,
  output logic                  over_o,
  output logic                  under_o
);
  logic wr_ctrl, wr_stat, wr_fmt;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign wr_ctrl = wr_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign wr_stat = wr_i && (reg_sel_e'(addr_i) == SEL_STAT);
  assign wr_fmt  = wr_i && (reg_sel_e'(addr_i) == SEL_FMT);
  assign push_o  = wr_i && (reg_sel_e'(addr_i) == SEL_DATA);
  assign push_data_o = wdata_i[SAMPLE_W-1:0];
  // flush is a pulse; a format change also restarts the store
  assign flush_o = (wr_ctrl && wdata_i[CTRL_FLUSH_BIT]) || wr_fmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_en_o <= 1'b0;
      chm1_o    <= '0;
    end else begin
      if (wr_ctrl) half_en_o <= wdata_i[CTRL_HALF_BIT];
      if (wr_fmt)  chm1_o    <= wdata_i[CHSEL_W-1:0];
    end
  end

  // error events win over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_o  <= 1'b0;
      under_o <= 1'b0;
    end else begin
      if (over_evt_i)                               over_o <= 1'b1;
      else if (wr_stat && !wdata_i[STAT_OVER_BIT])  over_o <= 1'b0;
      if (under_evt_i)                              under_o <= 1'b1;
      else if (wr_stat && !wdata_i[STAT_UNDER_BIT]) under_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      SEL_CTRL: rdata_o[CTRL_HALF_BIT] = half_en_o;
      SEL_STAT: begin
        rdata_o[STAT_FRAME_LSB +: FRAME_W] = frames_i;
        rdata_o[STAT_OVER_BIT]             = over_o;
        rdata_o[STAT_UNDER_BIT]            = under_o;
      end
      SEL_FMT:  rdata_o[CHSEL_W-1:0] = chm1_o;
      SEL_DATA: rdata_o = '0;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tx_sample_store.sv
module tx_sample_store
  import audio_tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                push_i,
  input  logic [SAMPLE_W-1:0] push_data_i,
  input  logic                pop_i,
  input  logic [CNT_W-1:0]    cap_words_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CNT_W-1:0]    word_cnt_o,
  output logic                push_ok_o,
  output logic                pop_ok_o,
  output logic                empty_o
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;

  assign empty_o   = (word_cnt_o == '0);
  assign push_ok_o = push_i && (word_cnt_o < cap_words_i);
  assign pop_ok_o  = pop_i && !empty_o;
  assign sample_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok_o && !flush_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      word_cnt_o <= '0;
    end else if (flush_i) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      word_cnt_o <= '0;
    end else begin
      if (push_ok_o) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_ok_o)  rd_ptr <= rd_ptr + PTR_W'(1);
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   word_cnt_o <= word_cnt_o + CNT_W'(1);
        2'b01:   word_cnt_o <= word_cnt_o - CNT_W'(1);
        default: word_cnt_o <= word_cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_track.sv
module tx_frame_track
  import audio_tx_fifo_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_ok_i,
  input  logic               pop_ok_i,
  input  logic [CHSEL_W-1:0] chm1_i,
  output logic [FRAME_W-1:0] frames_o
);
  logic [CHSEL_W-1:0] wr_slot, rd_slot;
  logic wr_done, rd_done;

  assign wr_done = push_ok_i && (wr_slot == chm1_i);
  assign rd_done = pop_ok_i && (rd_slot == chm1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot  <= '0;
      rd_slot  <= '0;
      frames_o <= '0;
    end else if (flush_i) begin
      wr_slot  <= '0;
      rd_slot  <= '0;
      frames_o <= '0;
    end else begin
      if (push_ok_i) wr_slot <= wr_done ? '0 : wr_slot + CHSEL_W'(1);
      if (pop_ok_i)  rd_slot <= rd_done ? '0 : rd_slot + CHSEL_W'(1);
      unique case ({wr_done, rd_done})
        2'b10:   frames_o <= frames_o + FRAME_W'(1);
        2'b01:   frames_o <= frames_o - FRAME_W'(1);
        default: frames_o <= frames_o;
      endcase
    end
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                pop_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                half_req_o
);
  logic                half_en, flush, push, push_ok, pop_ok, empty;
  logic                over_flag, under_flag;
  logic [CHSEL_W-1:0]  chm1;
  logic [SAMPLE_W-1:0] push_data;
  logic [FRAME_W-1:0]  frames;
  logic [CNT_W-1:0]    word_cnt, cap_words;

  // per-channel share is a power of two; capacity = share * channels
  always_comb begin
    unique case (chm1)
      3'd0, 3'd1, 3'd3, 3'd7: cap_words = CNT_W'(DEPTH);
      3'd2:                   cap_words = CNT_W'(DEPTH / 4 * 3);
      3'd4:                   cap_words = CNT_W'(DEPTH / 8 * 5);
      3'd5:                   cap_words = CNT_W'(DEPTH / 8 * 6);
      default:                cap_words = CNT_W'(DEPTH / 8 * 7);
    endcase
  end

  assign half_req_o = half_en && (word_cnt <= (cap_words >> 1));

  tx_reg_ctrl i_regs (
    .clk_i, .rst_ni,
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .over_evt_i  (push && !push_ok),
    .under_evt_i (pop_i && empty),
    .frames_i    (frames),
    .rdata_o     (reg_rdata_o),
    .half_en_o   (half_en),
    .chm1_o      (chm1),
    .flush_o     (flush),
    .push_o      (push),
    .push_data_o (push_data),
    .over_o      (over_flag),
    .under_o     (under_flag)
  );

  tx_sample_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_i),
    .cap_words_i (cap_words),
    .sample_o    (sample_o),
    .word_cnt_o  (word_cnt),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .empty_o     (empty)
  );

  tx_frame_track i_frames (
    .clk_i, .rst_ni,
    .flush_i   (flush),
    .push_ok_i (push_ok),
    .pop_ok_i  (pop_ok),
    .chm1_i    (chm1),
    .frames_o  (frames)
  );
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             pop_i,
  input logic [23:0]      sample_o,
  input logic [CNT_W-1:0] word_cnt_i,
  input logic [CNT_W-1:0] cap_words_i,
  input logic             over_i,
  input logic             under_i
);
  // R1
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd3 && word_cnt_i == '0 && cap_words_i != '0
    |=> sample_o == $past(reg_wdata_i[23:0]));
  // R2
  cap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt_i <= cap_words_i);
  // R4
  over_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd3 && word_cnt_i == cap_words_i |=> over_i);
  // R5
  under_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && word_cnt_i == '0 |=> under_i);
  // R5
  under_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt_i == '0 |-> sample_o == '0);
  // R6
  over_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_i && !(reg_wr_i && reg_addr_i == 2'd1 && !reg_wdata_i[4]) |=> over_i);
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[0] |=> word_cnt_i == '0);
  // R8
  flush_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd0 && !pop_i |=> $stable(over_i) && $stable(under_i));
  // R9
  fmt_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 2'd2 |=> word_cnt_i == '0);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .pop_i       (pop_i),
  .sample_o    (sample_o),
  .word_cnt_i  (word_cnt),
  .cap_words_i (cap_words),
  .over_i      (over_flag),
  .under_i     (under_flag)
);

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pop = 1'b0;
  logic [23:0] sample;
  logic        half_req;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  audio_tx_fifo #(.DEPTH(DEPTH)) i_audio_tx_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .pop_i(pop), .sample_o(sample), .half_req_o(half_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  function automatic int cap_of(input int ch);
    int per;
    per = (ch == 1) ? DEPTH : (ch == 2) ? DEPTH / 2 : (ch <= 4) ? DEPTH / 4 : DEPTH / 8;
    return per * ch;
  endfunction

  function automatic logic [23:0] pat(input int ch, input int i);
    return 24'(ch * 24'h111111 + i * 24'h000307 + 24'h00A000);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cap, fr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd(2'd1, r); check(r == 0, "R10 status", r, 0);
    rd(2'd2, r); check(r == 0, "R10 format", r, 0);
    rd(2'd0, r); check(r == 0, "R10 ctrl", r, 0);
    check(half_req == 0, "R10 half_req", half_req, 0);
    check(sample == 0, "R10 sample", sample, 0);

    wr(2'd0, 32'h0010_0000);
    rd(2'd0, r); check(r == 32'h0010_0000, "R7 ctrl readback", r, 32'h0010_0000);
    check(half_req == 1, "R7 half_req empty", half_req, 1);

    for (int ch = 1; ch <= 8; ch++) begin
      cap = cap_of(ch);
      wr(2'd2, 32'(ch - 1));
      rd(2'd2, r); check(r == 32'(ch - 1), "R2 format readback", r, ch - 1);
      for (int i = 0; i < cap; i++) begin
        wr(2'd3, {8'hC3, pat(ch, i)});
        rd(2'd1, r);
        fr = (i + 1) / ch;
        check(r[16:8] == 9'(fr), "R3 frames fill", r[16:8], fr);
        check(half_req == ((i + 1) <= cap / 2), "R7 half fill", half_req, (i + 1) <= cap / 2);
      end
      rd(2'd1, r); check(r[4] == 0, "R2 no overrun at capacity", r[4], 0);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd1, r);
      check(r[4] == 1, "R4 overrun set", r[4], 1);
      check(r[16:8] == 9'(cap / ch), "R4 frames unchanged", r[16:8], cap / ch);
      wr(2'd1, 32'h0000_0010);
      rd(2'd1, r); check(r[4] == 1, "R6 overrun kept by 1", r[4], 1);
      wr(2'd1, 32'h0);
      rd(2'd1, r); check(r[4] == 0, "R6 overrun cleared", r[4], 0);
      for (int j = 0; j < cap; j++) begin
        check(sample == pat(ch, j), "R1 order", sample, pat(ch, j));
        do_pop();
        rd(2'd1, r);
        fr = cap / ch - (j + 1) / ch;
        check(r[16:8] == 9'(fr), "R3 frames drain", r[16:8], fr);
        check(half_req == ((cap - j - 1) <= cap / 2), "R7 half drain", half_req, (cap - j - 1) <= cap / 2);
      end
      check(sample == 0, "R5 empty sample", sample, 0);
      do_pop();
      rd(2'd1, r);
      check(r[0] == 1, "R5 underrun set", r[0], 1);
      check(sample == 0, "R5 sample after underrun", sample, 0);
      wr(2'd1, 32'h0000_0001);
      rd(2'd1, r); check(r[0] == 1, "R6 underrun kept by 1", r[0], 1);
      wr(2'd1, 32'h0);
      rd(2'd1, r); check(r == 0, "R6 flags cleared", r, 0);
    end

    // R8 flush keeps flags
    wr(2'd2, 32'd1);
    for (int i = 0; i <= DEPTH; i++) wr(2'd3, {8'h00, pat(9, i)});
    do_pop(); do_pop(); do_pop();
    wr(2'd0, 32'h0010_0001);
    rd(2'd1, r);
    check(r[16:8] == 0, "R8 frames after flush", r[16:8], 0);
    check(r[4] == 1, "R8 overrun kept", r[4], 1);
    check(sample == 0, "R8 empty after flush", sample, 0);
    rd(2'd0, r); check(r == 32'h0010_0000, "R8 flush reads 0", r, 32'h0010_0000);
    wr(2'd3, 32'h1234_5678);
    check(sample == 24'h345678, "R8 R1 write after flush", sample, 24'h345678);
    do_pop();
    // R9 format write empties
    wr(2'd3, 32'h0000_0100); wr(2'd3, 32'h0000_0200);
    rd(2'd1, r); check(r[16:8] == 1, "R9 frames before", r[16:8], 1);
    wr(2'd2, 32'd0);
    rd(2'd1, r); check(r[16:8] == 0, "R9 frames after format", r[16:8], 0);
    check(sample == 0, "R9 empty after format", sample, 0);
    wr(2'd0, 32'h0);
    check(half_req == 0, "R7 half disabled", half_req, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule